// File: doc/BRIEF.md
# SPI Register Access Sequencer

This block runs complete single-register transactions against an SPI peripheral. A host presents one request carrying a direction flag, a 7-bit register address and, for writes, one data byte. The block lowers chip select, waits a settling time, and then performs two full-duplex byte exchanges while chip select stays low. It then raises chip select and pulses a completion flag.

A write puts the address on the wire with its top bit set to 1, followed by the value. A read puts the address with its top bit 0, followed by an all-ones filler byte. The byte the peripheral returns during that filler exchange becomes the read result. A small internal byte shifter generates the serial clock. The clock idles low, bits go out most significant first, the master updates its output on falling clock edges and samples the input on rising edges.

The request side uses valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so the host must hold `req_valid` and the request fields steady until that cycle. The completion side is a plain one-cycle pulse with no back-pressure.

Top module: `spi_reg_seq`

## Requirements
- R1: `req_ready` is high only when idle. A request is taken only on a cycle with `req_valid && req_ready`. `req_valid` held while busy starts nothing, and the next cycle after acceptance has `req_ready` low.
- R2: `spi_cs_n` falls on the clock edge that accepts a request and stays low until both bytes are fully shifted. `spi_sclk` is never high while `spi_cs_n` is high.
- R3: For a write, the first byte on `spi_mosi` is `{1'b1, req_addr}` and the second is `req_wdata`.
- R4: For a read, the first byte is `{1'b0, req_addr}` and the second is 8'hFF.
- R5: Each byte takes 8 rising edges of `spi_sclk`, for 16 per transaction, sent MSB first. `spi_sclk` idles low, and each high phase lasts `HALF_DIV` system clock cycles. `spi_mosi` changes only while `spi_sclk` is low, and `spi_miso` is captured on the rising edge.
- R6: The read result is the byte received during the second exchange. The byte received during the first exchange is discarded.
- R7: The first rising edge of `spi_sclk` comes at least `SETUP_CYC` system clock cycles after `spi_cs_n` falls.
- R8: Each byte completes before the next is loaded. The internal completion flag is cleared when the second byte is loaded and again once the second byte has been consumed.
- R9: `done` is a single-cycle pulse in the same cycle in which `spi_cs_n` returns high. For a read, `rdata` holds the result in that cycle. A write leaves `rdata` unchanged.
- R10: `spi_cs_n` stays high for at least `2*HALF_DIV` system clock cycles between consecutive transactions.
- R11: A synchronous active-low reset, even mid-transaction, gives `spi_cs_n`=1, `spi_sclk`=0, `done`=0, `rdata`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Value for a write |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 8 | Last read result |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to peripheral |
| spi_miso | input | 1 | Serial data from peripheral |

## Verification
The completion pulse and a new request can coincide. The bench provokes this by issuing the next request immediately, so `req_valid` is already high on the cycle in which `done` fires and chip select rises. It then judges that `req_ready` is low in that cycle, that no new transaction begins until the chip-select gap has elapsed, and that the scoreboard pairs each completion with exactly one queued request. A reset dropped into the middle of a byte shows that the aborted transaction produces no completion.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam logic [BYTE_W-1:0] FILL_BYTE = '1;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_FIRST,
    SQ_SECOND,
    SQ_HOLD,
    SQ_GAP
  } sq_state_e;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_reg_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clr,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              xfer_flag,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int HCW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BCW = $clog2(BYTE_W);
  localparam logic [HCW-1:0] HC_LAST = HCW'(HALF_DIV - 1);
  localparam logic [BCW-1:0] BC_LAST = BCW'(BYTE_W - 1);

  logic              busy;
  logic [HCW-1:0]    hcnt;
  logic [BCW-1:0]    bcnt;
  logic [BYTE_W-1:0] sh;

  // Output bit sits at the shift MSB; it only moves on a falling edge.
  assign mosi = busy & sh[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      hcnt      <= '0;
      bcnt      <= '0;
      sh        <= '0;
      rx_byte   <= '0;
      sclk      <= 1'b0;
      xfer_flag <= 1'b0;
    end else begin
      if (clr) xfer_flag <= 1'b0;
      if (start && !busy) begin
        sh        <= tx_byte;
        busy      <= 1'b1;
        hcnt      <= '0;
        bcnt      <= '0;
        sclk      <= 1'b0;
        xfer_flag <= 1'b0;
      end else if (busy) begin
        if (hcnt == HC_LAST) begin
          hcnt <= '0;
          if (!sclk) begin
            sclk    <= 1'b1;
            rx_byte <= {rx_byte[BYTE_W-2:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bcnt == BC_LAST) begin
              busy      <= 1'b0;
              xfer_flag <= 1'b1;
            end else begin
              bcnt <= bcnt + 1'b1;
              sh   <= {sh[BYTE_W-2:0], 1'b0};
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_build.sv
module spi_frame_build
  import spi_reg_pkg::*;
(
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              second,
  output logic [BYTE_W-1:0] out_byte
);
  always_comb begin
    if (!second)       out_byte = {is_write, addr};
    else if (is_write) out_byte = wdata;
    else               out_byte = FILL_BYTE;
  end
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_reg_pkg::*;
#(
  parameter int SETUP_CYC = 50,
  parameter int HOLD_CYC  = 4,
  parameter int GAP_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              xfer_flag,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              sh_start,
  output logic              sh_clr,
  output logic              second,
  output logic              lat_write,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [BYTE_W-1:0] lat_wdata,
  output logic              cs_n,
  output logic              done,
  output logic [BYTE_W-1:0] rdata
);
  localparam int MAX_SH = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_D  = (MAX_SH > GAP_CYC) ? MAX_SH : GAP_CYC;
  localparam int CW     = $clog2(MAX_D + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] GAP_LAST   = CW'(GAP_CYC - 1);

  sq_state_e st;
  logic [CW-1:0] dcnt;

  assign req_ready = (st == SQ_IDLE);
  assign second    = (st == SQ_FIRST);
  assign sh_start  = ((st == SQ_SETUP) && (dcnt == SETUP_LAST)) ||
                     ((st == SQ_FIRST) && xfer_flag);
  assign sh_clr    = ((st == SQ_FIRST) || (st == SQ_SECOND)) && xfer_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      dcnt      <= '0;
      cs_n      <= 1'b1;
      done      <= 1'b0;
      rdata     <= '0;
      lat_write <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (req_valid) begin
            lat_write <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            cs_n      <= 1'b0;
            dcnt      <= '0;
            st        <= SQ_SETUP;
          end
        end
        SQ_SETUP: begin
          if (dcnt == SETUP_LAST) st <= SQ_FIRST;
          else                    dcnt <= dcnt + 1'b1;
        end
        SQ_FIRST: begin
          if (xfer_flag) st <= SQ_SECOND;
        end
        SQ_SECOND: begin
          if (xfer_flag) begin
            if (!lat_write) rdata <= rx_byte;
            dcnt <= '0;
            st   <= SQ_HOLD;
          end
        end
        SQ_HOLD: begin
          if (dcnt == HOLD_LAST) begin
            cs_n <= 1'b1;
            done <= 1'b1;
            dcnt <= '0;
            st   <= SQ_GAP;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        SQ_GAP: begin
          if (dcnt == GAP_LAST) st <= SQ_IDLE;
          else                  dcnt <= dcnt + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_seq.sv
module spi_reg_seq
  import spi_reg_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int SETUP_CYC = 50,
  parameter int HOLD_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int GAP_CYC = 2 * HALF_DIV;

  logic              sh_start, sh_clr, xfer_flag, second, lat_write;
  logic [ADDR_W-1:0] lat_addr;
  logic [BYTE_W-1:0] lat_wdata, tx_byte, rx_byte;

  spi_seq_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_ready(req_ready),
    .xfer_flag(xfer_flag),
    .rx_byte  (rx_byte),
    .sh_start (sh_start),
    .sh_clr   (sh_clr),
    .second   (second),
    .lat_write(lat_write),
    .lat_addr (lat_addr),
    .lat_wdata(lat_wdata),
    .cs_n     (spi_cs_n),
    .done     (done),
    .rdata    (rdata)
  );

  spi_frame_build u_build (
    .is_write(lat_write),
    .addr    (lat_addr),
    .wdata   (lat_wdata),
    .second  (second),
    .out_byte(tx_byte)
  );

  spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sh_start),
    .clr      (sh_clr),
    .tx_byte  (tx_byte),
    .miso     (spi_miso),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .xfer_flag(xfer_flag),
    .rx_byte  (rx_byte)
  );
endmodule

// File: rtl/spi_reg_seq_chk.sv
module spi_reg_seq_chk #(
  parameter int HALF_DIV  = 4,
  parameter int SETUP_CYC = 50
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic spi_cs_n,
  input logic spi_sclk
);
  localparam int GAP = 2 * HALF_DIV;
  localparam int LIM = (SETUP_CYC > GAP) ? SETUP_CYC : GAP;
  localparam int W   = $clog2(LIM + 2);
  localparam logic [W-1:0] LIM_V   = W'(LIM);
  localparam logic [W-1:0] SETUP_V = W'(SETUP_CYC);
  localparam logic [W-1:0] GAP_V   = W'(GAP);

  logic [W-1:0] low_cnt, high_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= LIM_V;
    end else begin
      if (spi_cs_n) begin
        low_cnt <= '0;
        if (high_cnt != LIM_V) high_cnt <= high_cnt + 1'b1;
      end else begin
        high_cnt <= '0;
        if (low_cnt != LIM_V) low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  a_r1_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !spi_cs_n));

  a_r2_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);

  a_r7_setup_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> (low_cnt >= SETUP_V));

  a_r9_done_with_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(spi_cs_n));

  a_r9_cs_rise_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> done);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (high_cnt >= GAP_V));
endmodule

bind spi_reg_seq spi_reg_seq_chk #(
  .HALF_DIV (HALF_DIV),
  .SETUP_CYC(SETUP_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .spi_cs_n (spi_cs_n),
  .spi_sclk (spi_sclk)
);

// File: tb/spi_reg_seq_tb_top.sv
module spi_reg_seq_tb_top;
  localparam int HALF  = 3;
  localparam int SETUP = 10;
  localparam int HOLD  = 2;
  localparam int GAP   = 2 * HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, done, spi_cs_n, spi_sclk, spi_mosi;
  logic       spi_miso = 1'b0;
  logic [7:0] rdata;

  always #10 clk = ~clk;  // 50 MHz

  spi_reg_seq #(.HALF_DIV(HALF), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  typedef struct {
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] rd;
    bit         wr;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] reply_q[$];
  int total = 0, bad = 0, done_seen = 0, exp_done = 0;
  logic [7:0] last_rd = 8'h00;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Driver: pushes expected results, then performs the valid/ready handshake.
  task automatic do_txn(input bit wr, input logic [6:0] a, input logic [7:0] d,
                        input logic [7:0] reply);
    exp_t e;
    bit acc;
    e.wr = wr;
    e.b0 = {wr, a};
    e.b1 = wr ? d : 8'hFF;
    if (!wr) last_rd = reply;
    e.rd = last_rd;
    exp_q.push_back(e);
    reply_q.push_back(reply);
    exp_done++;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    forever begin
      acc = req_ready;
      @(negedge clk);
      if (acc) break;
    end
    chk("R1 ready low after accept", {31'd0, req_ready}, 0);
    req_valid = 1'b0;
  endtask

  // Slave model and monitor, sampled on the falling system clock edge.
  logic       prev_cs = 1'b1, prev_sclk = 1'b0, seen_rise = 1'b0;
  int         low_run = 0, hi_run = 0, gap_run = 1000, rises = 0;
  logic [15:0] mosi_sh = '0, sreg = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sclk = 1'b0; gap_run = 1000; rises = 0; hi_run = 0;
    end else begin
      if (prev_cs && !spi_cs_n) begin
        chk("R10 chip-select gap", {31'd0, gap_run >= GAP}, 1);
        low_run = 0; seen_rise = 1'b0; rises = 0; mosi_sh = '0;
        if (reply_q.size() > 0) begin
          logic [7:0] r;
          r = reply_q.pop_front();
          sreg = {~r, r};
        end else sreg = '0;
        spi_miso = sreg[15];
      end
      if (!spi_cs_n) low_run++;
      if (spi_cs_n) gap_run++; else gap_run = 0;
      if (spi_sclk && spi_cs_n) chk("R2 sclk idle while deselected", 1, 0);
      if (!prev_sclk && spi_sclk) begin
        mosi_sh = {mosi_sh[14:0], spi_mosi};
        rises++;
        hi_run = 0;
        if (!seen_rise) begin
          seen_rise = 1'b1;
          chk("R7 settle before first edge", {31'd0, low_run >= SETUP}, 1);
        end
      end
      if (spi_sclk) hi_run++;
      if (prev_sclk && !spi_sclk) begin
        chk("R5 high phase length", hi_run, HALF);
        sreg = sreg << 1;
        spi_miso = sreg[15];
      end
      if (done) begin
        done_seen++;
        chk("R9 cs high with done", {31'd0, spi_cs_n}, 1);
        chk("R1 not ready in done cycle", {31'd0, req_ready}, 0);
        chk("R5 sixteen clocks", rises, 16);
        if (exp_q.size() == 0) chk("R9 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.wr ? "R3 write first byte" : "R4 read first byte", {24'd0, mosi_sh[15:8]}, {24'd0, e.b0});
          chk(e.wr ? "R3 write second byte" : "R4 read second byte", {24'd0, mosi_sh[7:0]}, {24'd0, e.b1});
          chk(e.wr ? "R9 write keeps rdata" : "R6 read result", {24'd0, rdata}, {24'd0, e.rd});
        end
      end
      if (prev_cs == 1'b0 && spi_cs_n && !done) chk("R8 cs rose without done", 1, 0);
      prev_cs = spi_cs_n;
      prev_sclk = spi_sclk;
    end
  end

  task automatic wait_idle();
    while (exp_q.size() > 0 || !req_ready) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 cs_n in reset", {31'd0, spi_cs_n}, 1);
    chk("R11 sclk in reset", {31'd0, spi_sclk}, 0);
    chk("R11 ready in reset", {31'd0, req_ready}, 1);
    chk("R11 done in reset", {31'd0, done}, 0);
    chk("R11 rdata in reset", {24'd0, rdata}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_txn(1, 7'h15, 8'hA5, 8'h5A); wait_idle();
    do_txn(0, 7'h15, 8'h00, 8'h3C); wait_idle();
    do_txn(0, 7'h7F, 8'h11, 8'h00); wait_idle();
    do_txn(1, 7'h00, 8'hFF, 8'h77); wait_idle();
    do_txn(0, 7'h01, 8'h00, 8'hFF); wait_idle();
    // Back-to-back: next request already pending across each done pulse.
    do_txn(1, 7'h2A, 8'h81, 8'hC3);
    do_txn(0, 7'h2A, 8'h00, 8'h96);
    do_txn(1, 7'h55, 8'h01, 8'h10);
    do_txn(0, 7'h40, 8'h00, 8'h81);
    wait_idle();

    // Reset mid-transaction: no done may follow.
    do_txn(1, 7'h33, 8'hEE, 8'h44);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 cs_n after abort", {31'd0, spi_cs_n}, 1);
    chk("R11 sclk after abort", {31'd0, spi_sclk}, 0);
    chk("R11 ready after abort", {31'd0, req_ready}, 1);
    chk("R11 rdata after abort", {24'd0, rdata}, 0);
    exp_q.delete(); reply_q.delete();
    exp_done--;
    last_rd = 8'h00;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_txn(1, 7'h0F, 8'h5A, 8'h00); wait_idle();
    chk("R9 rdata still reset value after write", {24'd0, rdata}, 0);
    do_txn(0, 7'h0F, 8'h00, 8'hE7); wait_idle();
    repeat (10) @(negedge clk);
    chk("R1 one done per request", done_seen, exp_done);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got=timeout expected=completion");
    finish_run();
  end
endmodule